// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power state of a microcontroller clock system. It keeps one normal operating mode and four low-power modes: doze, sleep, deep-sleep and power-down. Normal and doze also carry a high/low frequency sub-state. That sub-state picks which of two divider values drives the clock divider. Software selects a mode by writing a 3-bit code, together with a clock-source bit, through a one-cycle write strobe. Low-power entry is allowed only when the processor power bit is set and the low-power lock bit is clear. Codes are honoured only while the block sits in normal mode.

An asynchronous exit event passes through a two-flop synchronizer. While the block is in any low-power mode, this event forces it back to normal-high. The block drives three clock enables: one for the CPU domain, one for the peripheral domain and one for the system clock as a whole. It also drives the registered divider value and the current mode code. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in normal mode at high frequency. `mode_code` is 000, `freq_high` is 1, `clk_src` is 0, `div_out` is 0, and all three clock enables are 1.
- R2: In normal mode a write of code 000 selects normal-high and a write of code 001 selects normal-low. Both take effect at the write edge, whatever the values of `pwr_en` and `lp_lock`.
- R3: In normal mode, writes of 010 (doze), 011 (sleep), 100 (deep-sleep) and 101 (power-down) enter that mode only if `pwr_en` is 1 and `lp_lock` is 0. Otherwise the mode does not change.
- R4: Codes 110 and 111 leave both the mode and the frequency state unchanged.
- R5: Outside normal mode, and in particular in doze, every write is ignored. This covers both the mode code and the clock-source bit.
- R6: The exit event is synchronized by two flops. If it is high at a rising edge while the block is in a low-power mode, the block becomes normal-high (code 000) at the second rising edge after that one. In normal mode the exit event has no effect. The exit event wins over a write in the same cycle.
- R7: Doze keeps the frequency sub-state it was entered with. Entered from normal-low, it reports `freq_high`=0.
- R8: On each rising edge in normal or doze mode, `div_out` loads `hi_div` if the frequency state is high, or `lo_div` if it is low. In sleep, deep-sleep and power-down it holds its value.
- R9: `cpu_clk_en` is 1 only in normal mode. `per_clk_en` is 1 in normal and doze modes. `sys_clk_en` is 0 only in power-down.
- R10: A write in normal mode loads `wr_clk_src` into `clk_src`, whatever the code written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the mode register |
| wr_mode | input | 3 | Mode code to write |
| wr_clk_src | input | 1 | Clock-source select to write |
| pwr_en | input | 1 | Processor power-enable bit |
| lp_lock | input | 1 | Low-power lock; 1 blocks entry |
| wake_async | input | 1 | Asynchronous low-power exit event |
| hi_div | input | DIV_W | Divider value for high frequency |
| lo_div | input | DIV_W | Divider value for low frequency |
| mode_code | output | 3 | Current mode code |
| freq_high | output | 1 | 1 when the high frequency state is selected |
| div_out | output | DIV_W | Registered active divider value |
| clk_src | output | 1 | Current clock-source select |
| cpu_clk_en | output | 1 | CPU domain clock enable |
| per_clk_en | output | 1 | Peripheral domain clock enable |
| sys_clk_en | output | 1 | System clock enable |

## Verification
The assertions assume the following about the inputs:
- `wr_en` and the control bits are synchronous to `clk`.
- The exit event may change at any time.
- The divider inputs may change every cycle.

The stimulus keeps to these assumptions. It drives every input on the falling edge only. The exit event comes as short random pulses. The enable bits are weighted so that entry is sometimes allowed and sometimes blocked. Directed sequences cover writes inside doze and power-down, locked and unpowered entry, the reserved codes, and the exact exit latency.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_NORMAL = 3'd0,
    M_DOZE   = 3'd1,
    M_SLEEP  = 3'd2,
    M_DEEP   = 3'd3,
    M_PDOWN  = 3'd4
  } lp_mode_e;

  localparam logic [2:0] C_NORM_HI = 3'b000;
  localparam logic [2:0] C_NORM_LO = 3'b001;
  localparam logic [2:0] C_DOZE    = 3'b010;
  localparam logic [2:0] C_SLEEP   = 3'b011;
  localparam logic [2:0] C_DEEP    = 3'b100;
  localparam logic [2:0] C_PDOWN   = 3'b101;

  function automatic logic [2:0] code_of(input lp_mode_e m, input logic fhi);
    case (m)
      M_NORMAL: code_of = fhi ? C_NORM_HI : C_NORM_LO;
      M_DOZE:   code_of = C_DOZE;
      M_SLEEP:  code_of = C_SLEEP;
      M_DEEP:   code_of = C_DEEP;
      default:  code_of = C_PDOWN;
    endcase
  endfunction

  function automatic logic is_low(input lp_mode_e m);
    is_low = (m != M_NORMAL);
  endfunction

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [2:0] wr_mode,
  input  logic      wr_clk_src,
  input  logic      pwr_en,
  input  logic      lp_lock,
  input  logic      wake_s,
  output lp_mode_e  mode_q,
  output logic      fhi_q,
  output logic      src_q
);
  lp_mode_e mode_n;
  logic     fhi_n, src_n;
  logic     entry_ok;

  assign entry_ok = pwr_en && !lp_lock;

  always_comb begin
    mode_n = mode_q;
    fhi_n  = fhi_q;
    src_n  = src_q;
    if (wake_s && is_low(mode_q)) begin
      mode_n = M_NORMAL;
      fhi_n  = 1'b1;
    end else if (wr_en && (mode_q == M_NORMAL)) begin
      src_n = wr_clk_src;
      case (wr_mode)
        C_NORM_HI: fhi_n = 1'b1;
        C_NORM_LO: fhi_n = 1'b0;
        C_DOZE:    if (entry_ok) mode_n = M_DOZE;
        C_SLEEP:   if (entry_ok) mode_n = M_SLEEP;
        C_DEEP:    if (entry_ok) mode_n = M_DEEP;
        C_PDOWN:   if (entry_ok) mode_n = M_PDOWN;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NORMAL;
      fhi_q  <= 1'b1;
      src_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      fhi_q  <= fhi_n;
      src_q  <= src_n;
    end
  end

  // R3: no low-power entry while entry is not permitted
  a_r3_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORMAL && !(pwr_en && !lp_lock)) |=> (mode_q == M_NORMAL));

  // R4: reserved codes change nothing in normal mode
  a_r4_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_q == M_NORMAL && wr_mode[2] && wr_mode[1])
      |=> (mode_q == M_NORMAL && $stable(fhi_q)));

  // R5 and R7: doze holds mode, frequency state and clock source unless woken
  a_r5_doze_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DOZE && !wake_s)
      |=> (mode_q == M_DOZE && $stable(src_q) && $stable(fhi_q)));

  // R6: synchronized exit returns to normal-high
  a_r6_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_s && mode_q != M_NORMAL) |=> (mode_q == M_NORMAL && fhi_q));

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lp_mode_e         mode,
  input  logic             fhi,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  output logic [DIV_W-1:0] div_out,
  output logic             cpu_en,
  output logic             per_en,
  output logic             sys_en
);
  logic div_live;

  assign div_live = (mode == M_NORMAL) || (mode == M_DOZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_out <= '0;
    else if (div_live) div_out <= fhi ? hi_div : lo_div;
  end

  assign cpu_en = (mode == M_NORMAL);
  assign per_en = div_live;
  assign sys_en = (mode != M_PDOWN);

  // R8: divider frozen in the deeper modes
  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP || mode == M_DEEP || mode == M_PDOWN) |=> $stable(div_out));

  // R9: enables nest: CPU implies peripheral, peripheral implies system
  a_r9_enable_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_en || per_en) && (!per_en || sys_en));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_mode,
  input  logic             wr_clk_src,
  input  logic             pwr_en,
  input  logic             lp_lock,
  input  logic             wake_async,
  input  logic [DIV_W-1:0] hi_div,
  input  logic [DIV_W-1:0] lo_div,
  output logic [2:0]       mode_code,
  output logic             freq_high,
  output logic [DIV_W-1:0] div_out,
  output logic             clk_src,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             sys_clk_en
);
  logic     wake_s;
  lp_mode_e mode;
  logic     fhi;

  lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wake_async), .sync_out(wake_s)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_clk_src(wr_clk_src), .pwr_en(pwr_en), .lp_lock(lp_lock),
    .wake_s(wake_s), .mode_q(mode), .fhi_q(fhi), .src_q(clk_src)
  );

  lpm_clk_ctrl #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fhi(fhi),
    .hi_div(hi_div), .lo_div(lo_div), .div_out(div_out),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en), .sys_en(sys_clk_en)
  );

  assign mode_code = code_of(mode, fhi);
  assign freq_high = fhi;

  // R1/R2: the reported code is always one of the six defined values
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code <= 3'b101);

endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_mode = 3'd0;
  logic wr_clk_src = 1'b0;
  logic pwr_en = 1'b0;
  logic lp_lock = 1'b0;
  logic wake_async = 1'b0;
  logic [DW-1:0] hi_div = 4'd3;
  logic [DW-1:0] lo_div = 4'd12;
  logic [2:0] mode_code;
  logic freq_high, clk_src, cpu_clk_en, per_clk_en, sys_clk_en;
  logic [DW-1:0] div_out;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpm_ctrl #(.DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_clk_src(wr_clk_src), .pwr_en(pwr_en), .lp_lock(lp_lock),
    .wake_async(wake_async), .hi_div(hi_div), .lo_div(lo_div),
    .mode_code(mode_code), .freq_high(freq_high), .div_out(div_out),
    .clk_src(clk_src), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .sys_clk_en(sys_clk_en)
  );

  // reference model: 0 normal, 1 doze, 2 sleep, 3 deep, 4 power-down
  int m_mode;
  bit m_fhi, m_src, m_s1, m_s2;
  logic [DW-1:0] m_div;

  function automatic logic [2:0] exp_code(int md, bit fh);
    if (md == 0) return fh ? 3'b000 : 3'b001;
    return 3'(md + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_fhi <= 1'b1; m_src <= 1'b0;
      m_div <= '0; m_s1 <= 1'b0; m_s2 <= 1'b0;
    end else begin
      m_s1 <= wake_async;
      m_s2 <= m_s1;
      if (m_mode <= 1) m_div <= m_fhi ? hi_div : lo_div;
      if (m_s2 && m_mode != 0) begin
        m_mode <= 0; m_fhi <= 1'b1;
      end else if (wr_en && m_mode == 0) begin
        m_src <= wr_clk_src;
        if (wr_mode == 3'd0) m_fhi <= 1'b1;
        else if (wr_mode == 3'd1) m_fhi <= 1'b0;
        else if (wr_mode <= 3'd5 && pwr_en && !lp_lock) m_mode <= int'(wr_mode) - 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3 mode code", mode_code, exp_code(m_mode, m_fhi));
    check("R7 freq state", freq_high, m_fhi);
    check("R8 divider", div_out, m_div);
    check("R10 clock source", clk_src, m_src);
    check("R9 cpu enable", cpu_clk_en, m_mode == 0);
    check("R9 per enable", per_clk_en, m_mode <= 1);
    check("R9 sys enable", sys_clk_en, m_mode != 4);
  endtask

  // one cycle: drive at falling edge, settle through the next falling edge
  task automatic cyc(bit we, logic [2:0] code, bit src);
    wr_en = we; wr_mode = code; wr_clk_src = src;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset code", mode_code, 0);
    check("R1 reset freq", freq_high, 1);
    check("R1 reset src", clk_src, 0);
    check("R1 reset div", div_out, 3);
    check("R1 reset enables", {cpu_clk_en, per_clk_en, sys_clk_en}, 7);

    pwr_en = 1'b1; lp_lock = 1'b0;
    cyc(1, 3'b001, 0);
    check("R2 normal-low", mode_code, 1);
    cyc(0, 0, 0);
    check("R8 low divider", div_out, 12);
    cyc(1, 3'b010, 0);
    check("R3 doze entry", mode_code, 2);
    check("R7 doze keeps low", freq_high, 0);
    check("R9 doze cpu off", cpu_clk_en, 0);
    check("R9 doze per on", per_clk_en, 1);
    cyc(1, 3'b000, 1);
    check("R5 doze write ignored", mode_code, 2);
    check("R5 doze src ignored", clk_src, 0);

    wake_async = 1'b1;
    cyc(0, 0, 0);
    wake_async = 1'b0;
    check("R6 wake edge 1", mode_code, 2);
    cyc(0, 0, 0);
    check("R6 wake edge 2", mode_code, 2);
    cyc(0, 0, 0);
    check("R6 wake exit", mode_code, 0);
    check("R6 wake high", freq_high, 1);

    lp_lock = 1'b1;
    cyc(1, 3'b011, 1);
    check("R3 locked entry", mode_code, 0);
    check("R10 src written", clk_src, 1);
    lp_lock = 1'b0; pwr_en = 1'b0;
    cyc(1, 3'b011, 1);
    check("R3 unpowered entry", mode_code, 0);
    pwr_en = 1'b1;
    cyc(1, 3'b001, 1);
    cyc(1, 3'b110, 1);
    check("R4 code 110", mode_code, 1);
    cyc(1, 3'b111, 1);
    check("R4 code 111", mode_code, 1);
    cyc(1, 3'b000, 1);
    cyc(1, 3'b101, 0);
    check("R3 power-down", mode_code, 5);
    check("R9 power-down sys off", sys_clk_en, 0);
    cyc(1, 3'b000, 1);
    check("R5 power-down write ignored", mode_code, 5);
    hi_div = 4'd7;
    cyc(0, 0, 0);
    check("R8 divider held", div_out, 3);
    compare_all();

    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      pwr_en     = ($urandom % 4) != 0;
      lp_lock    = ($urandom % 4) == 0;
      wake_async = ($urandom % 16) == 0;
      hi_div     = DW'($urandom);
      lo_div     = DW'($urandom);
      cyc(($urandom % 3) == 0, 3'($urandom), 1'($urandom));
      compare_all();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule